// File: doc/BRIEF.md
# Automatic Modem-Line Flow Control

This block handles the automatic modem-line handshake for one UART channel. It has two independent halves.

The first half is the outgoing request-to-send line, `rts_n`. It stops the remote sender when the local receive FIFO nears full, and lets it resume once the FIFO has drained. Two programmable thresholds set these points, and the gap between them gives hysteresis. When automatic mode is off, a host bit drives the line directly.

The second half is the incoming clear-to-send line, `cts_n`. The block synchronizes it, and every change on the synchronized line sets a sticky interrupt flag. When the automatic mode for this line is on, the line also grants or withholds permission for the transmitter to start its next character. A character that is already being shifted out always completes. The automatic mode for this line can only be turned on while the transmitter is switched off. A request made at any other time is refused and sets a sticky error flag.

The serializer, the FIFOs and the host register decoding sit outside this block. The block only sees the transmitter-off bit, the character-busy indication, the FIFO fill count and the configuration levels.

Top module: `uart_modem_flow`

## Requirements
- R1: After reset, `cts_irq` and `cfg_err` read 0, automatic CTS mode is off, the RTS stop state is clear, and the CTS synchronizer holds the deasserted level 1.
- R2: `cts_n` passes through a two-flop synchronizer. A level change on `cts_n` driven between edges k and k+1 reaches the synchronized line at edge k+2. It sets `cts_irq` at edge k+3, and it does so whether or not automatic CTS mode is on.
- R3: `cts_irq` and `cfg_err` stay set until `flag_clr` is sampled high. If a new set event arrives in the same cycle as the clear, the set wins.
- R4: A cycle with `cfg_wr`=1 loads `cfg_auto_cts`. A value of 0 always turns automatic CTS mode off. A value of 1 turns it on only if `tx_off`=1. Otherwise the request is refused, automatic CTS mode keeps its previous state, and `cfg_err` is set at the next edge.
- R5: With automatic CTS mode on, `char_busy`=0 and `tx_off`=0, `tx_allowed` is 0 while the synchronized CTS is 1 (deasserted) and 1 while it is 0 (asserted).
- R6: While `char_busy`=1, `tx_allowed` is 1, so the character in flight completes. A CTS stop only blocks the start of the next character.
- R7: With `char_busy`=0, `tx_allowed` is 0 whenever `tx_off`=1.
- R8: With automatic CTS mode off, `cts_n` has no effect on `tx_allowed`.
- R9: The RTS stop state is set at the edge after `rx_fill` >= `thr_high` is sampled. This test takes priority over the low test.
- R10: The RTS stop state is cleared at the edge after `rx_fill` <= `thr_low` is sampled (and `rx_fill` < `thr_high`). Between the two thresholds it holds.
- R11: With `auto_rts`=1, `rts_n` equals the stop state (1 = stop the remote sender). With `auto_rts`=0, `rts_n` is the inverse of `manual_rts`. The stop state keeps tracking the fill level in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cts_n | input | 1 | Clear-to-send line, active low, asynchronous |
| char_busy | input | 1 | Serializer is shifting out a character |
| tx_off | input | 1 | Transmitter-disable configuration bit |
| cfg_wr | input | 1 | One-cycle write strobe for the automatic CTS enable |
| cfg_auto_cts | input | 1 | Requested automatic CTS enable value |
| auto_rts | input | 1 | Automatic RTS mode enable |
| manual_rts | input | 1 | Host RTS request (1 = assert) used when automatic RTS is off |
| flag_clr | input | 1 | Clears the interrupt and error flags |
| rx_fill | input | CNT_W | Receive FIFO fill count |
| thr_high | input | CNT_W | Fill level that stops the remote sender |
| thr_low | input | CNT_W | Fill level that lets the remote sender resume |
| tx_allowed | output | 1 | Transmitter may start or continue a character |
| rts_n | output | 1 | Request-to-send line, active low |
| cts_irq | output | 1 | Sticky CTS change interrupt flag |
| cfg_err | output | 1 | Sticky refused-enable error flag |

## Verification
Directed sequences come first. They walk the fill count up through the high threshold and back down through the low one, so that holding between the thresholds is told apart from a single-threshold compare. They also toggle CTS with automatic mode both on and off, which shows that the interrupt is independent of gating. They request the automatic CTS enable with the transmitter both on and off, which separates acceptance from refusal. A long random run follows. It mixes sparse CTS toggles, drifting fill counts, shuffled thresholds, busy pulses, enable writes and flag clears. Every output is compared on every cycle against a bench reference model, which exposes synchronizer latency, set-versus-clear priority and the threshold priority when the thresholds cross.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;
  // Modem lines are active low: 0 means asserted.
  typedef enum logic {
    LINE_ON  = 1'b0,
    LINE_OFF = 1'b1
  } line_e;

  // Sticky flag update: a set event wins over a clear in the same cycle.
  function automatic logic sticky_next(logic cur, logic set_ev, logic clr);
    if (set_ev)   return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction
endpackage

// File: rtl/flow_cts_sync.sv
module flow_cts_sync
  import uart_flow_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cts_n,
  input  logic flag_clr,
  output logic cts_n_sync,
  output logic cts_edge,
  output logic cts_irq
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q;
  logic         last_q;
  logic         irq_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= LINE_OFF;
          else        sync_q[0] <= cts_n;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[i] <= LINE_OFF;
          else        sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= LINE_OFF;
      irq_q  <= 1'b0;
    end else begin
      last_q <= sync_q[TOP];
      irq_q  <= sticky_next(irq_q, cts_edge, flag_clr);
    end
  end

  assign cts_n_sync = sync_q[TOP];
  assign cts_edge   = sync_q[TOP] ^ last_q;
  assign cts_irq    = irq_q;

  // R2: a synchronized edge raises the interrupt at the next edge
  a_r2_edge_sets_irq: assert property (@(posedge clk) disable iff (!rst_n)
    cts_edge |=> cts_irq);
  // R3: flag holds unless cleared without a concurrent edge
  a_r3_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cts_irq && !flag_clr) |=> cts_irq);
endmodule

// File: rtl/flow_cts_gate.sv
module flow_cts_gate
  import uart_flow_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_wr,
  input  logic cfg_auto_cts,
  input  logic tx_off,
  input  logic cts_n_sync,
  input  logic char_busy,
  input  logic flag_clr,
  output logic tx_allowed,
  output logic cfg_err
);
  logic auto_cts_q;
  logic err_q;
  logic refused;
  logic cts_stop;
  logic start_ok;

  assign refused  = cfg_wr && cfg_auto_cts && !tx_off;
  assign cts_stop = auto_cts_q && (cts_n_sync == LINE_OFF);
  assign start_ok = !tx_off && !cts_stop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_cts_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (cfg_wr) begin
        if (!cfg_auto_cts) auto_cts_q <= 1'b0;
        else if (tx_off)   auto_cts_q <= 1'b1;
      end
      err_q <= sticky_next(err_q, refused, flag_clr);
    end
  end

  // A character in flight always completes; only new starts are gated.
  assign tx_allowed = char_busy || start_ok;
  assign cfg_err    = err_q;

  // R4: a refused request sets the error and leaves the mode unchanged
  a_r4_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    refused |=> (cfg_err && auto_cts_q == $past(auto_cts_q)));
  // R5: automatic mode with deasserted CTS blocks a new start
  a_r5_cts_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_cts_q && cts_n_sync && !char_busy) |-> !tx_allowed);
  // R6: busy character never cut off
  a_r6_busy_runs: assert property (@(posedge clk) disable iff (!rst_n)
    char_busy |-> tx_allowed);
  // R7: transmitter off blocks a new start
  a_r7_off_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_off && !char_busy) |-> !tx_allowed);
endmodule

// File: rtl/flow_rts_hyst.sv
module flow_rts_hyst #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [CNT_W-1:0] thr_high,
  input  logic [CNT_W-1:0] thr_low,
  input  logic             auto_rts,
  input  logic             manual_rts,
  output logic             rts_n
);
  localparam logic [CNT_W-1:0] FILL_ZERO = '0;

  logic stop_q;
  logic stop_d;

  // High test first; between thresholds the state holds.
  function automatic logic stop_next(logic cur, logic [CNT_W-1:0] fill,
                                     logic [CNT_W-1:0] hi, logic [CNT_W-1:0] lo);
    if (fill >= hi)      return 1'b1;
    else if (fill <= lo) return 1'b0;
    else                 return cur;
  endfunction

  assign stop_d = stop_next(stop_q, rx_fill, thr_high, thr_low);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stop_q <= 1'b0;
    else        stop_q <= stop_d;

  assign rts_n = auto_rts ? stop_q : !manual_rts;

  // R9: reaching the high threshold stops the remote sender
  a_r9_high_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill >= thr_high) |=> stop_q);
  // R10: draining to the low threshold releases it
  a_r10_low_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill <= thr_low && rx_fill < thr_high) |=> !stop_q);
  // R10: between the thresholds the state holds
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fill > thr_low && rx_fill < thr_high) |=> $stable(stop_q));
  // R11: automatic mode drives the line from the stop state
  a_r11_auto_line: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rts && rx_fill >= thr_high && rx_fill != FILL_ZERO) |=> (rts_n || !auto_rts));
endmodule

// File: rtl/uart_modem_flow.sv
module uart_modem_flow #(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cts_n,
  input  logic             char_busy,
  input  logic             tx_off,
  input  logic             cfg_wr,
  input  logic             cfg_auto_cts,
  input  logic             auto_rts,
  input  logic             manual_rts,
  input  logic             flag_clr,
  input  logic [CNT_W-1:0] rx_fill,
  input  logic [CNT_W-1:0] thr_high,
  input  logic [CNT_W-1:0] thr_low,
  output logic             tx_allowed,
  output logic             rts_n,
  output logic             cts_irq,
  output logic             cfg_err
);
  logic cts_n_sync;
  logic cts_edge;

  flow_cts_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .flag_clr(flag_clr),
    .cts_n_sync(cts_n_sync), .cts_edge(cts_edge), .cts_irq(cts_irq)
  );

  flow_cts_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_auto_cts(cfg_auto_cts),
    .tx_off(tx_off), .cts_n_sync(cts_n_sync), .char_busy(char_busy),
    .flag_clr(flag_clr), .tx_allowed(tx_allowed), .cfg_err(cfg_err)
  );

  flow_rts_hyst #(.CNT_W(CNT_W)) u_rts (
    .clk(clk), .rst_n(rst_n), .rx_fill(rx_fill), .thr_high(thr_high),
    .thr_low(thr_low), .auto_rts(auto_rts), .manual_rts(manual_rts),
    .rts_n(rts_n)
  );

  // R1: flags are clear in the first cycle after reset release
  a_r1_flags_reset: assert property (@(posedge clk)
    $rose(rst_n) |-> (!cts_irq && !cfg_err));
endmodule

// File: tb/uart_modem_flow_test.sv
`timescale 1ns/1ps
module uart_modem_flow_test;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cts_n = 1'b1, char_busy = 1'b0, tx_off = 1'b1, cfg_wr = 1'b0;
  logic cfg_auto_cts = 1'b0, auto_rts = 1'b0, manual_rts = 1'b0, flag_clr = 1'b0;
  logic [W-1:0] rx_fill = '0, thr_high = 8'd200, thr_low = 8'd50;
  logic tx_allowed, rts_n, cts_irq, cfg_err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_modem_flow #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cts_n(cts_n), .char_busy(char_busy),
    .tx_off(tx_off), .cfg_wr(cfg_wr), .cfg_auto_cts(cfg_auto_cts),
    .auto_rts(auto_rts), .manual_rts(manual_rts), .flag_clr(flag_clr),
    .rx_fill(rx_fill), .thr_high(thr_high), .thr_low(thr_low),
    .tx_allowed(tx_allowed), .rts_n(rts_n), .cts_irq(cts_irq), .cfg_err(cfg_err)
  );

  // Reference model state, built from the requirements
  logic m_s1, m_s2, m_prev, m_irq, m_err, m_auto, m_stop;

  function automatic logic flag_upd(logic cur, logic ev, logic clr);
    return ev ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction

  function automatic logic hyst(logic cur, logic [W-1:0] f, logic [W-1:0] h, logic [W-1:0] l);
    if (f >= h) return 1'b1;   // R9
    if (f <= l) return 1'b0;   // R10
    return cur;
  endfunction

  function automatic logic exp_tx();
    logic blocked;
    if (char_busy) return 1'b1;                 // R6
    if (tx_off) return 1'b0;                    // R7
    blocked = m_auto && m_s2;                   // R5, R8
    return !blocked;
  endfunction

  function automatic logic exp_rts();
    return auto_rts ? m_stop : !manual_rts;     // R11
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 1'b1; m_s2 <= 1'b1; m_prev <= 1'b1;
      m_irq <= 1'b0; m_err <= 1'b0; m_auto <= 1'b0; m_stop <= 1'b0;
    end else begin
      m_s1 <= cts_n; m_s2 <= m_s1; m_prev <= m_s2;                   // R2
      m_irq <= flag_upd(m_irq, m_s2 != m_prev, flag_clr);            // R3
      m_err <= flag_upd(m_err, cfg_wr && cfg_auto_cts && !tx_off, flag_clr);
      if (cfg_wr) begin                                              // R4
        if (!cfg_auto_cts) m_auto <= 1'b0;
        else if (tx_off)   m_auto <= 1'b1;
      end
      m_stop <= hyst(m_stop, rx_fill, thr_high, thr_low);
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all();
    chk("R5 R6 R7 R8", "tx_allowed", tx_allowed, exp_tx());
    chk("R9 R10 R11", "rts_n", rts_n, exp_rts());
    chk("R2 R3", "cts_irq", cts_irq, m_irq);
    chk("R4", "cfg_err", cfg_err, m_err);
  endtask

  // Check the settled outputs, then let the caller drive the next inputs.
  task automatic step();
    @(negedge clk);
    chk_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      step();
      cfg_wr = 1'b0; flag_clr = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "cts_irq in reset", cts_irq, 1'b0);
    chk("R1", "cfg_err in reset", cfg_err, 1'b0);
    chk("R1", "tx_allowed off", tx_allowed, 1'b0);
    rst_n = 1'b1;
    idle(2);

    // R4: enable with transmitter off is accepted
    cfg_wr = 1'b1; cfg_auto_cts = 1'b1; tx_off = 1'b1;
    idle(1);
    tx_off = 1'b0;
    idle(4);
    chk("R5", "deasserted CTS blocks start", tx_allowed, 1'b0);
    cts_n = 1'b0;
    idle(1);
    chk("R2", "one edge: not yet visible", tx_allowed, 1'b0);
    idle(1);
    chk("R5", "asserted CTS allows start", tx_allowed, 1'b1);
    idle(1);
    chk("R2", "irq after CTS change", cts_irq, 1'b1);
    // R6: in-flight char continues while CTS stops
    char_busy = 1'b1; cts_n = 1'b1;
    idle(4);
    chk("R6", "busy keeps tx", tx_allowed, 1'b1);
    char_busy = 1'b0;
    idle(1);
    chk("R5", "next start blocked", tx_allowed, 1'b0);
    // R3: clear wins only without a new event
    flag_clr = 1'b1;
    idle(1);
    chk("R3", "irq cleared", cts_irq, 1'b0);
    // R4: refused request, mode unchanged, then disable
    cfg_wr = 1'b1; cfg_auto_cts = 1'b0;
    idle(1);
    cfg_wr = 1'b1; cfg_auto_cts = 1'b1;
    idle(1);
    chk("R4", "error on refused enable", cfg_err, 1'b1);
    chk("R8", "refused enable leaves CTS ignored", tx_allowed, 1'b1);
    cts_n = 1'b0; idle(3); cts_n = 1'b1; idle(3);
    chk("R8", "CTS ignored when off", tx_allowed, 1'b1);
    chk("R2", "irq without automatic mode", cts_irq, 1'b1);

    // R9 R10: hysteresis walk with automatic RTS
    auto_rts = 1'b1;
    for (int f = 0; f <= 210; f += 10) begin rx_fill = W'(f); idle(1); end
    chk("R9", "stop at high", rts_n, 1'b1);
    for (int f = 190; f >= 60; f -= 10) begin rx_fill = W'(f); idle(1); end
    chk("R10", "hold between thresholds", rts_n, 1'b1);
    rx_fill = 8'd50; idle(2);
    chk("R10", "release at low", rts_n, 1'b0);
    // R11: manual control
    auto_rts = 1'b0; manual_rts = 1'b1; idle(1);
    chk("R11", "manual assert", rts_n, 1'b0);

    // Random phase
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 20000; i++) begin
      step();
      if ($urandom_range(7) == 0) cts_n = ~cts_n;
      char_busy = ($urandom_range(3) == 0);
      tx_off = ($urandom_range(5) == 0) ? ~tx_off : tx_off;
      cfg_wr = ($urandom_range(15) == 0);
      cfg_auto_cts = $urandom_range(1);
      flag_clr = ($urandom_range(9) == 0);
      if ($urandom_range(63) == 0) auto_rts = ~auto_rts;
      if ($urandom_range(31) == 0) manual_rts = ~manual_rts;
      if ($urandom_range(3) == 0) rx_fill = W'($urandom);
      else rx_fill = rx_fill + W'($urandom_range(4)) - W'(2);
      if ($urandom_range(255) == 0) begin
        thr_high = W'($urandom); thr_low = W'($urandom);
      end
    end
    step();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule